// File: doc/BRIEF.md
# Prefetch Buffer Fill Command Sequencer

This block steps through one four-quadword cache line and issues one command per beat, so that quadwords read from a second-level cache can land in a read prefetch buffer. A start request gives the quadword that was asked for and the kind of SRAM behind the cache. With burst SRAM, the quadwords come in interleaved order. With asynchronous SRAM, they come in linear order. On every beat the block gives the cache quadword address and a 5-bit command.

The requested quadword always goes into buffer entry 0, and each later quadword goes into the entry equal to its distance above the request. Quadwords below the request are not buffered: in an interleaved burst those beats still happen but carry a no-op, and a linear burst stops at the end of the line instead of wrapping. In write-hit mode the line is invalidated rather than buffered. Every beat then carries a post-to-memory command instead of a buffer store.

Top module: `prefetch_fill_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `beat_valid_o`=0, `qw_addr_o`=0, `cmd_o`=5'h00, `done_o`=0 and `busy_o`=0.
- R2: With `linear_i`=0, the quadword addresses on beats 0..3 are 0,1,2,3 for start 0; 1,0,3,2 for start 1; 2,3,0,1 for start 2; and 3,2,1,0 for start 3.
- R3: In a non-write-hit burst, a beat whose quadword q is at or above the start s carries the store command 5'h01+(q-s), so entries 0..3 are 5'h01..5'h04.
- R4: In an interleaved burst, a beat whose quadword is below the start has `beat_valid_o`=1 and carries the no-op command 5'h00.
- R5: With `linear_i`=1, the quadword address rises by one per beat from the start, and the stores go into entries 0,1,2,... in that order.
- R6: A linear burst lasts exactly 4 minus start beats and never wraps to quadword 0.
- R7: A start accepted at a clock edge produces the first beat one edge later. Beats follow on consecutive cycles, and an interleaved burst lasts exactly 4 beats.
- R8: When `wr_hit_i` was 1 at acceptance, every beat of the burst carries 5'h08 (post write to memory) and no store command.
- R9: `done_o` is 1 on the last beat of each burst and 0 at every other time.
- R10: `busy_o` rises at the edge that accepts a start and falls at the edge that presents the last beat. A `start_i` seen while `busy_o` is 1 is ignored, along with its fields.
- R11: Outside a beat, `cmd_o` holds 5'h00 and `qw_addr_o` holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| start_qw_i | input | 2 | Requested quadword index |
| linear_i | input | 1 | 1 = asynchronous SRAM (linear order), 0 = burst SRAM (interleaved order) |
| wr_hit_i | input | 1 | 1 = post the line to memory instead of filling the buffer |
| beat_valid_o | output | 1 | A beat is present on the address and command outputs |
| qw_addr_o | output | 2 | Cache quadword address of this beat |
| cmd_o | output | 5 | Command of this beat |
| done_o | output | 1 | Last beat of the burst |
| busy_o | output | 1 | Burst in progress; new starts are ignored |

## Verification
A corrupted beat counter or captured start index shows up on the very next beat. It appears as a wrong `qw_addr_o`, a store into the wrong entry, or a no-op where a store belongs. A wrong length decision shows up at the end of the burst, as `done_o` on the wrong beat or an extra or missing beat. Because the bench compares every output on every cycle against a behavioural model, each fault is reported in the cycle where it first appears. Exhaustive start/mode/write-hit combinations, starts held high across back-to-back bursts, and a reset in mid-burst exercise each path.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int CMD_W = 5;
  typedef logic [CMD_W-1:0] cmd_t;
  localparam cmd_t CMD_NOP        = 5'h00;
  localparam cmd_t CMD_STORE_BASE = 5'h01;
  localparam cmd_t CMD_POST_MEM   = 5'h08;
endpackage

// File: rtl/pfs_ctrl.sv
module pfs_ctrl #(
  parameter int LINE_QW = 4,
  localparam int QW_W = $clog2(LINE_QW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [QW_W-1:0] start_qw_i,
  input  logic            linear_i,
  input  logic            wr_hit_i,
  output logic            active_o,
  output logic [QW_W-1:0] beat_o,
  output logic [QW_W-1:0] base_o,
  output logic            linear_o,
  output logic            wr_o,
  output logic            last_o
);
  localparam logic [QW_W-1:0] TOP = QW_W'(LINE_QW - 1);

  logic            active_q;
  logic [QW_W-1:0] beat_q, base_q;
  logic            lin_q, wr_q;

  // linear bursts stop at the line end; interleaved bursts cover the line
  assign last_o = lin_q ? (beat_q == TOP - base_q) : (beat_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      lin_q    <= 1'b0;
      wr_q     <= 1'b0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        base_q   <= start_qw_i;
        lin_q    <= linear_i;
        wr_q     <= wr_hit_i;
      end
    end else if (last_o) begin
      active_q <= 1'b0;
    end else begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign linear_o = lin_q;
  assign wr_o     = wr_q;

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    active_q && !last_o |=> active_q); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    active_q && start_i |=> $stable(base_q) && $stable(lin_q) && $stable(wr_q)); // R10
endmodule

// File: rtl/pfs_addr_gen.sv
module pfs_addr_gen #(
  parameter int LINE_QW = 4,
  localparam int QW_W = $clog2(LINE_QW)
) (
  input  logic [QW_W-1:0] base_i,
  input  logic [QW_W-1:0] beat_i,
  input  logic            linear_i,
  output logic [QW_W-1:0] qw_o
);
  logic [QW_W-1:0] ilv, lin;

  genvar b;
  generate
    for (b = 0; b < QW_W; b++) begin : g_ilv
      assign ilv[b] = base_i[b] ^ beat_i[b];
    end
  endgenerate

  // never overflows: the burst ends before passing the top quadword
  assign lin  = base_i + beat_i;
  assign qw_o = linear_i ? lin : ilv;
endmodule

// File: rtl/pfs_cmd_map.sv
module pfs_cmd_map
  import pfs_pkg::*;
#(
  parameter int LINE_QW = 4,
  localparam int QW_W = $clog2(LINE_QW)
) (
  input  logic [QW_W-1:0] qw_i,
  input  logic [QW_W-1:0] base_i,
  input  logic            wr_i,
  output cmd_t            cmd_o
);
  logic [QW_W-1:0] entry;
  assign entry = qw_i - base_i;

  always_comb begin
    if (wr_i)               cmd_o = CMD_POST_MEM;
    else if (qw_i < base_i) cmd_o = CMD_NOP;
    else                    cmd_o = CMD_STORE_BASE + cmd_t'(entry);
  end
endmodule

// File: rtl/prefetch_fill_seq.sv
module prefetch_fill_seq
  import pfs_pkg::*;
#(
  parameter int LINE_QW = 4,
  localparam int QW_W = $clog2(LINE_QW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [QW_W-1:0] start_qw_i,
  input  logic            linear_i,
  input  logic            wr_hit_i,
  output logic            beat_valid_o,
  output logic [QW_W-1:0] qw_addr_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic            done_o,
  output logic            busy_o
);
  logic            active, lin, wr, last;
  logic [QW_W-1:0] beat, base, qw;
  cmd_t            cmd;

  pfs_ctrl #(.LINE_QW(LINE_QW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .start_qw_i(start_qw_i),
    .linear_i(linear_i), .wr_hit_i(wr_hit_i), .active_o(active),
    .beat_o(beat), .base_o(base), .linear_o(lin), .wr_o(wr), .last_o(last)
  );

  pfs_addr_gen #(.LINE_QW(LINE_QW)) u_addr (
    .base_i(base), .beat_i(beat), .linear_i(lin), .qw_o(qw)
  );

  pfs_cmd_map #(.LINE_QW(LINE_QW)) u_map (
    .qw_i(qw), .base_i(base), .wr_i(wr), .cmd_o(cmd)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      beat_valid_o <= 1'b0;
      qw_addr_o    <= '0;
      cmd_o        <= CMD_NOP;
      done_o       <= 1'b0;
    end else begin
      beat_valid_o <= 1'b1;
      qw_addr_o    <= qw;
      cmd_o        <= cmd;
      done_o       <= last;
    end
  end

  assign busy_o = active;

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    !beat_valid_o |-> cmd_o == CMD_NOP && qw_addr_o == '0); // R11
  AST_DONE_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> beat_valid_o); // R9
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |=> beat_valid_o); // R7
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R10
endmodule

// File: tb/test_prefetch_fill_seq.sv
module test_prefetch_fill_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] start_qw_i = 2'd0;
  logic       linear_i = 1'b0;
  logic       wr_hit_i = 1'b0;
  logic       beat_valid_o, done_o, busy_o;
  logic [1:0] qw_addr_o;
  logic [4:0] cmd_o;

  int errors = 0, checks = 0, cyc = 0;
  bit chk_en = 0, finished = 0;

  always #2 clk = ~clk;

  prefetch_fill_seq i_prefetch_fill_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .start_qw_i(start_qw_i),
    .linear_i(linear_i), .wr_hit_i(wr_hit_i), .beat_valid_o(beat_valid_o),
    .qw_addr_o(qw_addr_o), .cmd_o(cmd_o), .done_o(done_o), .busy_o(busy_o)
  );

  // behavioural reference
  int ord [4][4] = '{'{0,1,2,3}, '{1,0,3,2}, '{2,3,0,1}, '{3,2,1,0}};
  int m_act = 0, m_bt = 0, m_s = 0, m_lin = 0, m_wr = 0;
  int e_v = 0, e_addr = 0, e_cmd = 0, e_done = 0, e_busy = 0;
  int o_lin = 0, o_wr = 0, o_rst = 1;

  always @(posedge clk) begin
    int q, len;
    if (rst) begin
      m_act = 0; m_bt = 0; e_v = 0; e_addr = 0; e_cmd = 0; e_done = 0; o_rst = 1;
    end else begin
      o_rst = 0;
      if (m_act != 0) begin
        q   = (m_lin != 0) ? m_s + m_bt : ord[m_s][m_bt];
        len = (m_lin != 0) ? 4 - m_s : 4;
        e_v = 1; e_addr = q; o_lin = m_lin; o_wr = m_wr;
        e_cmd  = (m_wr != 0) ? 8 : ((q >= m_s) ? q - m_s + 1 : 0);
        e_done = (m_bt == len - 1) ? 1 : 0;
        if (e_done != 0) m_act = 0; else m_bt = m_bt + 1;
      end else begin
        e_v = 0; e_addr = 0; e_cmd = 0; e_done = 0;
        if (start_i) begin
          m_act = 1; m_bt = 0; m_s = int'(start_qw_i);
          m_lin = int'(linear_i); m_wr = int'(wr_hit_i);
        end
      end
    end
    e_busy = m_act;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en && !finished) begin
    if (o_rst != 0) begin
      chk("R1 valid", int'(beat_valid_o), e_v);
      chk("R1 addr", int'(qw_addr_o), e_addr);
      chk("R1 cmd", int'(cmd_o), e_cmd);
      chk("R1 done", int'(done_o), e_done);
      chk("R1 busy", int'(busy_o), e_busy);
    end else begin
      chk((o_lin != 0) ? "R6 valid" : "R7 valid", int'(beat_valid_o), e_v);
      if (e_v == 0) begin
        chk("R11 addr", int'(qw_addr_o), e_addr);
        chk("R11 cmd", int'(cmd_o), e_cmd);
      end else begin
        chk((o_lin != 0) ? "R5 addr" : "R2 addr", int'(qw_addr_o), e_addr);
        if (o_wr != 0)       chk("R8 cmd", int'(cmd_o), e_cmd);
        else if (o_lin != 0) chk("R5 cmd", int'(cmd_o), e_cmd);
        else if (e_cmd == 0) chk("R4 cmd", int'(cmd_o), e_cmd);
        else                 chk("R3 cmd", int'(cmd_o), e_cmd);
      end
      chk("R9 done", int'(done_o), e_done);
      chk("R10 busy", int'(busy_o), e_busy);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic burst(int s, int lin, int wr);
    @(negedge clk);
    start_i = 1'b1; start_qw_i = 2'(s); linear_i = lin[0]; wr_hit_i = wr[0];
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(posedge clk); @(negedge clk);
    chk_en = 1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // all starts, both orders, both write modes (R2-R9)
    for (int wr = 0; wr < 2; wr++)
      for (int lin = 0; lin < 2; lin++)
        for (int s = 0; s < 4; s++)
          burst(s, lin, wr);
    // start held high: back-to-back bursts, starts ignored while busy (R10)
    @(negedge clk);
    start_i = 1'b1; start_qw_i = 2'd1; linear_i = 1'b1; wr_hit_i = 1'b0;
    repeat (12) @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    // mid-burst start with different fields must not alter the burst (R10)
    start_i = 1'b1; start_qw_i = 2'd0; linear_i = 1'b0; wr_hit_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; start_qw_i = 2'd3; linear_i = 1'b1; wr_hit_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    // reset in mid-burst (R1)
    burst(2, 0, 0);
    start_i = 1'b1; start_qw_i = 2'd1; linear_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    burst(3, 1, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule